// File: doc/BRIEF.md
# Card Erase and Write-Protect Validator

This block is the card-side checker for erase, block-write and write-protect commands. A command strobe carries a 6-bit command index and a 32-bit argument. From the capacity class, the card size and a small map of write-protect groups, the block decides in one clock cycle which error flags the command raises. It also decides whether the command is illegal for this card and whether an erase goes ahead. Data storage, response framing and CRC are handled elsewhere. The block only reports what the surrounding card logic must do.

The block latches the erase range from the erase-start and erase-end commands. The erase command consumes both latched addresses. On a high-capacity card, command addresses are 512-byte block numbers, and the block converts them to byte addresses before any check. Write-protect groups exist only on standard-capacity cards. Each group is 2^GRP_SHIFT bytes, and the map holds GROUPS of them. The protect map and the sticky status word are visible on output ports, and a status-clear strobe empties the status word.

Top module: `card_protect_validator`

## Requirements
- R1: After reset, `status`, `wp_bits`, `prot_word`, `rsp_valid`, `rsp_busy`, `illegal`, `erase_done` and `csd_erase_flag` are all zero.
- R2: On a standard-capacity card, command 28 sets and command 29 clears the protect bit of group `byte_addr >> GRP_SHIFT`, where `wp_bits[g]` is group g. The response that follows has `rsp_busy`=1. An address at or above `card_size` sets status bit 1 (address error) and leaves `wp_bits` unchanged.
- R3: On a standard-capacity card, command 30 loads `prot_word`, whose bit i is the protect bit of group (arg >> GRP_SHIFT) + i, or 0 when that group does not exist. Its response has `rsp_busy`=0.
- R4: On a high-capacity card, commands 28, 29 and 30 give a one-cycle `illegal` pulse with no `rsp_valid`, and `wp_bits` does not change.
- R5: Commands 24 and 25 set status bit 1 when byte address + 512 exceeds `card_size`. On a high-capacity card the byte address is arg × 512.
- R6: A block write that is in range sets status bit 2 (write-protect violation) in either of two cases: its group is protected on a standard-capacity card, or `csd_prot` is nonzero. On a high-capacity card the group map is ignored.
- R7: Command 38 scales the latched start and end by 512 on a high-capacity card. If either scaled value exceeds `card_size`, it sets status bit 0 (out of range), gives no `erase_done`, and invalidates both latched addresses.
- R8: Command 38 with both addresses latched (by commands 32 and 33) and in range gives a one-cycle `erase_done` and sets `csd_erase_flag`, which stays set. It also invalidates both addresses. Command 38 while either address is invalid sets status bit 4 (erase sequence error) and does nothing else.
- R9: A standard-capacity erase that goes ahead sets status bit 3 (erase skip) if any group from the start group to the end group inclusive is protected. A high-capacity erase never sets bit 3.
- R10: Status bits stay set until `stat_clr`. An error raised in the same cycle as `stat_clr` is kept.
- R11: Command indices other than 24, 25, 28, 29, 30, 32, 33 and 38 produce no response, no status and no state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_index | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| high_cap | input | 1 | 1 = high-capacity card |
| card_size | input | SIZE_W | Card size in bytes |
| csd_prot | input | 2 | Card-wide write-protect bits |
| stat_clr | input | 1 | Status read strobe, clears the status word |
| status | output | 5 | Sticky error flags, bits 0..4 as in R2 to R9 |
| wp_bits | output | GROUPS | Write-protect group map |
| prot_word | output | 32 | Send-protect result word |
| rsp_valid | output | 1 | One-cycle pulse: command accepted |
| rsp_busy | output | 1 | With rsp_valid: response carries busy |
| illegal | output | 1 | One-cycle pulse: command illegal for this card |
| erase_done | output | 1 | One-cycle pulse: erase performed |
| csd_erase_flag | output | 1 | Sticky erased marker for the card-data byte |

## Verification
The assertions assume at most one command per strobe cycle. They also assume that `card_size` and `high_cap` are steady around each command, so a registered pulse can be traced back to the inputs of the previous cycle. The stimulus drives every input on the falling edge, pulses `cmd_valid` for exactly one cycle, and changes `high_cap` and `card_size` only while no command is in flight. The group-map stability check assumes that protect updates come only from commands 28 and 29. The bench therefore never relies on any other path to change `wp_bits`.

// File: rtl/cpv_pkg.sv
package cpv_pkg;
   localparam int ST_W    = 5;
   localparam int ST_OOR  = 0;
   localparam int ST_ADDR = 1;
   localparam int ST_WPV  = 2;
   localparam int ST_SKIP = 3;
   localparam int ST_SEQ  = 4;

   localparam logic [5:0] CMD_WR_ONE    = 6'd24;
   localparam logic [5:0] CMD_WR_MULTI  = 6'd25;
   localparam logic [5:0] CMD_PROT_SET  = 6'd28;
   localparam logic [5:0] CMD_PROT_CLR  = 6'd29;
   localparam logic [5:0] CMD_PROT_SEND = 6'd30;
   localparam logic [5:0] CMD_ER_START  = 6'd32;
   localparam logic [5:0] CMD_ER_END    = 6'd33;
   localparam logic [5:0] CMD_ERASE     = 6'd38;

   localparam int HC_SHIFT = 9;
endpackage

// File: rtl/cpv_addr_scale.sv
module cpv_addr_scale #(
   parameter int SIZE_W = 41
) (
   input  logic [31:0]       arg,
   input  logic              hc,
   output logic [SIZE_W-1:0] byte_addr
);
   import cpv_pkg::*;

   generate
      if (SIZE_W < 32 + HC_SHIFT) begin : g_bad_width
         $error("cpv_addr_scale: SIZE_W too small for scaled block numbers");
      end
   endgenerate

   always_comb begin
      if (hc) byte_addr = SIZE_W'(arg) << HC_SHIFT;
      else    byte_addr = SIZE_W'(arg);
   end
endmodule

// File: rtl/cpv_wp_map.sv
module cpv_wp_map #(
   parameter int GROUPS    = 32,
   parameter int SIZE_W    = 41,
   parameter int GRP_SHIFT = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_en,
   input  logic              clr_en,
   input  logic [SIZE_W-1:0] upd_addr,
   input  logic [SIZE_W-1:0] chk_addr,
   input  logic [SIZE_W-1:0] rng_lo,
   input  logic [SIZE_W-1:0] rng_hi,
   output logic [GROUPS-1:0] bits,
   output logic              chk_hit,
   output logic              rng_hit,
   output logic [31:0]       win_word
);
   localparam int EXT_W = GROUPS + 32;

   generate
      if (GROUPS < 1 || GROUPS > 64) begin : g_bad_groups
         $error("cpv_wp_map: GROUPS out of range");
      end
      if (GRP_SHIFT < 9 || GRP_SHIFT >= SIZE_W) begin : g_bad_shift
         $error("cpv_wp_map: GRP_SHIFT out of range");
      end
   endgenerate

   logic [SIZE_W-1:0] upd_g, chk_g, lo_g, hi_g;
   logic [GROUPS-1:0] rng_mask, chk_mask;
   logic [EXT_W-1:0]  ext;

   assign upd_g = upd_addr >> GRP_SHIFT;
   assign chk_g = chk_addr >> GRP_SHIFT;
   assign lo_g  = rng_lo   >> GRP_SHIFT;
   assign hi_g  = rng_hi   >> GRP_SHIFT;

   genvar g;
   generate
      for (g = 0; g < GROUPS; g++) begin : g_grp
         logic prot_q;
         logic sel;
         assign sel = (upd_g == SIZE_W'(g));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)             prot_q <= 1'b0;
            else if (set_en && sel) prot_q <= 1'b1;
            else if (clr_en && sel) prot_q <= 1'b0;
         end
         assign bits[g]     = prot_q;
         assign rng_mask[g] = (lo_g <= SIZE_W'(g)) && (SIZE_W'(g) <= hi_g);
         assign chk_mask[g] = (chk_g == SIZE_W'(g));
      end
   endgenerate

   assign rng_hit  = |(rng_mask & bits);
   assign chk_hit  = |(chk_mask & bits);
   assign ext      = EXT_W'(bits) >> chk_g;
   assign win_word = ext[31:0];

   // R2
   map_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(set_en || clr_en) |=> $stable(bits));
endmodule

// File: rtl/cpv_status.sv
module cpv_status #(
   parameter int W = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic [W-1:0] raise,
   output logic [W-1:0] status
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   status <= '0;
      else if (clr) status <= raise;
      else          status <= status | raise;
   end

   // R10
   status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> ((status & $past(status)) == $past(status)));

   // R10
   raise_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (raise != '0) |=> ((status & $past(raise)) == $past(raise)));
endmodule

// File: rtl/card_protect_validator.sv
module card_protect_validator #(
   parameter int GROUPS    = 32,
   parameter int GRP_SHIFT = 12,
   parameter int SIZE_W    = 41,
   parameter int BLK_LEN   = 512
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [5:0]        cmd_index,
   input  logic [31:0]       cmd_arg,
   input  logic              high_cap,
   input  logic [SIZE_W-1:0] card_size,
   input  logic [1:0]        csd_prot,
   input  logic              stat_clr,
   output logic [4:0]        status,
   output logic [GROUPS-1:0] wp_bits,
   output logic [31:0]       prot_word,
   output logic              rsp_valid,
   output logic              rsp_busy,
   output logic              illegal,
   output logic              erase_done,
   output logic              csd_erase_flag
);
   import cpv_pkg::*;

   localparam int SUM_W = SIZE_W + 1;

   generate
      if (BLK_LEN < 1) begin : g_bad_blk
         $error("card_protect_validator: BLK_LEN must be positive");
      end
   endgenerate

   logic [SIZE_W-1:0] cmd_addr, es_b, ee_b;
   logic [31:0]       er_start, er_end;
   logic              er_start_ok, er_end_ok;
   logic              is_wr, is_set, is_clr, is_send, is_prot;
   logic              is_estart, is_eend, is_erase;
   logic              std_card, set_en, clr_en, prot_addr_bad;
   logic              wr_addr_bad, er_oor, er_go, er_ok;
   logic              chk_hit, rng_hit;
   logic [31:0]       win_word;
   logic [ST_W-1:0]   raise;

   cpv_addr_scale #(.SIZE_W(SIZE_W)) u_cmd_scale (
      .arg(cmd_arg), .hc(high_cap), .byte_addr(cmd_addr));
   cpv_addr_scale #(.SIZE_W(SIZE_W)) u_es_scale (
      .arg(er_start), .hc(high_cap), .byte_addr(es_b));
   cpv_addr_scale #(.SIZE_W(SIZE_W)) u_ee_scale (
      .arg(er_end), .hc(high_cap), .byte_addr(ee_b));

   always_comb begin
      std_card  = !high_cap;
      is_wr     = cmd_valid && (cmd_index == CMD_WR_ONE || cmd_index == CMD_WR_MULTI);
      is_set    = cmd_valid && (cmd_index == CMD_PROT_SET);
      is_clr    = cmd_valid && (cmd_index == CMD_PROT_CLR);
      is_send   = cmd_valid && (cmd_index == CMD_PROT_SEND);
      is_estart = cmd_valid && (cmd_index == CMD_ER_START);
      is_eend   = cmd_valid && (cmd_index == CMD_ER_END);
      is_erase  = cmd_valid && (cmd_index == CMD_ERASE);
      is_prot   = is_set || is_clr || is_send;

      prot_addr_bad = (is_set || is_clr) && std_card && (cmd_addr >= card_size);
      set_en        = is_set && std_card && !prot_addr_bad;
      clr_en        = is_clr && std_card && !prot_addr_bad;

      wr_addr_bad = is_wr &&
         ((SUM_W'(cmd_addr) + SUM_W'(BLK_LEN)) > SUM_W'(card_size));

      er_oor = (es_b > card_size) || (ee_b > card_size);
      er_go  = is_erase && er_start_ok && er_end_ok;
      er_ok  = er_go && !er_oor;

      raise          = '0;
      raise[ST_OOR]  = er_go && er_oor;
      raise[ST_ADDR] = wr_addr_bad || prot_addr_bad;
      raise[ST_WPV]  = is_wr && !wr_addr_bad &&
                       ((std_card && chk_hit) || (csd_prot != 2'b00));
      raise[ST_SKIP] = er_ok && std_card && rng_hit;
      raise[ST_SEQ]  = is_erase && !(er_start_ok && er_end_ok);
   end

   cpv_wp_map #(.GROUPS(GROUPS), .SIZE_W(SIZE_W), .GRP_SHIFT(GRP_SHIFT)) u_map (
      .clk(clk), .rst_n(rst_n), .set_en(set_en), .clr_en(clr_en),
      .upd_addr(cmd_addr), .chk_addr(cmd_addr), .rng_lo(es_b), .rng_hi(ee_b),
      .bits(wp_bits), .chk_hit(chk_hit), .rng_hit(rng_hit), .win_word(win_word));

   cpv_status #(.W(ST_W)) u_status (
      .clk(clk), .rst_n(rst_n), .clr(stat_clr), .raise(raise), .status(status));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         er_start       <= '0;
         er_end         <= '0;
         er_start_ok    <= 1'b0;
         er_end_ok      <= 1'b0;
         rsp_valid      <= 1'b0;
         rsp_busy       <= 1'b0;
         illegal        <= 1'b0;
         erase_done     <= 1'b0;
         csd_erase_flag <= 1'b0;
         prot_word      <= '0;
      end else begin
         rsp_valid  <= is_wr || is_erase || is_estart || is_eend || (is_prot && std_card);
         rsp_busy   <= is_erase || ((is_set || is_clr) && std_card);
         illegal    <= is_prot && high_cap;
         erase_done <= er_ok;
         if (er_ok) csd_erase_flag <= 1'b1;
         if (is_send && std_card) prot_word <= win_word;
         if (er_go) begin
            er_start_ok <= 1'b0;
            er_end_ok   <= 1'b0;
         end else begin
            if (is_estart) begin
               er_start    <= cmd_arg;
               er_start_ok <= 1'b1;
            end
            if (is_eend) begin
               er_end    <= cmd_arg;
               er_end_ok <= 1'b1;
            end
         end
      end
   end

   // R4
   illegal_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> !rsp_valid);

   // R4
   illegal_hc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(illegal) |-> $past(high_cap));

   // R3
   send_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && $past(cmd_index) == CMD_PROT_SEND) |-> !rsp_busy);

   // R8
   erase_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      erase_done |-> csd_erase_flag);

   // R8
   erase_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      erase_done |=> !erase_done);
endmodule

// File: tb/tb_card_protect_validator.sv
module tb_card_protect_validator;
   localparam int GROUPS = 32;
   localparam int GSH    = 12;
   localparam int SW     = 41;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cmd_valid = 1'b0;
   logic [5:0]        cmd_index = '0;
   logic [31:0]       cmd_arg = '0;
   logic              high_cap = 1'b0;
   logic [SW-1:0]     card_size = SW'(131072);
   logic [1:0]        csd_prot = 2'b00;
   logic              stat_clr = 1'b0;
   logic [4:0]        status;
   logic [GROUPS-1:0] wp_bits;
   logic [31:0]       prot_word;
   logic              rsp_valid, rsp_busy, illegal, erase_done, csd_erase_flag;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   card_protect_validator #(.GROUPS(GROUPS), .GRP_SHIFT(GSH), .SIZE_W(SW)) dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_index(cmd_index),
      .cmd_arg(cmd_arg), .high_cap(high_cap), .card_size(card_size),
      .csd_prot(csd_prot), .stat_clr(stat_clr), .status(status), .wp_bits(wp_bits),
      .prot_word(prot_word), .rsp_valid(rsp_valid), .rsp_busy(rsp_busy),
      .illegal(illegal), .erase_done(erase_done), .csd_erase_flag(csd_erase_flag));

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic cmd(input logic [5:0] idx, input logic [31:0] arg);
      cmd_index = idx;
      cmd_arg   = arg;
      cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic clear_status();
      stat_clr = 1'b1;
      @(negedge clk);
      stat_clr = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 status", 64'(status), 0);
      chk("R1 wp_bits", 64'(wp_bits), 0);
      chk("R1 outputs", 64'({prot_word, rsp_valid, rsp_busy, illegal, erase_done, csd_erase_flag}), 0);
   endtask

   task automatic t_protect();
      cmd(6'd28, 32'(3 << GSH));
      chk("R2 set rsp", 64'({rsp_valid, rsp_busy}), 64'b11);
      chk("R2 set g3", 64'(wp_bits), 64'h8);
      cmd(6'd28, 32'(5 << GSH));
      chk("R2 set g5", 64'(wp_bits), 64'h28);
      cmd(6'd30, 32'(2 << GSH));
      chk("R3 send word", 64'(prot_word), 64'hA);
      chk("R3 send rsp", 64'({rsp_valid, rsp_busy}), 64'b10);
      cmd(6'd30, 32'(31 << GSH));
      chk("R3 send tail", 64'(prot_word), 64'h0);
      cmd(6'd29, 32'(3 << GSH));
      chk("R2 clr g3", 64'(wp_bits), 64'h20);
      cmd(6'd28, 32'd131072);
      chk("R2 bad addr status", 64'(status), 64'b00010);
      chk("R2 bad addr map", 64'(wp_bits), 64'h20);
      clear_status();
      chk("R10 cleared", 64'(status), 0);
   endtask

   task automatic t_write();
      cmd(6'd24, 32'(5 << GSH));
      chk("R6 protected group", 64'(status), 64'b00100);
      chk("R10 sticky", 64'(status), 64'b00100);
      clear_status();
      cmd(6'd25, 32'd0);
      chk("R6 free group", 64'(status), 0);
      cmd(6'd24, 32'd131072 - 32'd512);
      chk("R5 last block ok", 64'(status), 0);
      cmd(6'd24, 32'd131072 - 32'd511);
      chk("R5 past end", 64'(status), 64'b00010);
      clear_status();
      csd_prot = 2'b01;
      cmd(6'd25, 32'd0);
      chk("R6 csd prot", 64'(status), 64'b00100);
      csd_prot = 2'b00;
      clear_status();
   endtask

   task automatic t_clear_race();
      stat_clr = 1'b1;
      cmd(6'd24, 32'(5 << GSH));
      stat_clr = 1'b0;
      chk("R10 raise beats clear", 64'(status), 64'b00100);
      clear_status();
   endtask

   task automatic t_erase_std();
      cmd(6'd32, 32'd0);
      cmd(6'd33, 32'(4 << GSH));
      cmd(6'd38, 32'd0);
      chk("R8 done pulse", 64'({erase_done, csd_erase_flag, rsp_busy}), 64'b111);
      chk("R9 no skip", 64'(status), 0);
      @(negedge clk);
      chk("R8 pulse one cycle", 64'(erase_done), 0);
      cmd(6'd32, 32'd0);
      cmd(6'd33, 32'(5 << GSH));
      cmd(6'd38, 32'd0);
      chk("R9 skip", 64'({erase_done, status}), 64'b1_01000);
      clear_status();
      cmd(6'd38, 32'd0);
      chk("R8 invalidated", 64'({erase_done, status}), 64'b0_10000);
      clear_status();
      cmd(6'd32, 32'd0);
      cmd(6'd33, 32'd131073);
      cmd(6'd38, 32'd0);
      chk("R7 std oor", 64'({erase_done, status}), 64'b0_00001);
      clear_status();
      cmd(6'd38, 32'd0);
      chk("R7 oor invalidates", 64'(status), 64'b10000);
      clear_status();
   endtask

   task automatic t_hc();
      high_cap  = 1'b1;
      card_size = SW'(64'd1 << 30);
      @(negedge clk);
      cmd(6'd28, 32'd0);
      chk("R4 set illegal", 64'({illegal, rsp_valid}), 64'b10);
      chk("R4 map kept", 64'(wp_bits), 64'h20);
      cmd(6'd30, 32'd0);
      chk("R4 send illegal", 64'({illegal, rsp_valid}), 64'b10);
      cmd(6'd32, 32'd0);
      cmd(6'd33, 32'd2097152);
      cmd(6'd38, 32'd0);
      chk("R9 hc no skip", 64'({erase_done, status}), 64'b1_00000);
      cmd(6'd32, 32'd0);
      cmd(6'd33, 32'd2097153);
      cmd(6'd38, 32'd0);
      chk("R7 hc oor", 64'({erase_done, status}), 64'b0_00001);
      clear_status();
      cmd(6'd24, 32'd40);
      chk("R6 hc ignores map", 64'(status), 0);
      cmd(6'd25, 32'd2097151);
      chk("R5 hc last block", 64'(status), 0);
      cmd(6'd24, 32'd2097152);
      chk("R5 hc past end", 64'(status), 64'b00010);
      clear_status();
      high_cap  = 1'b0;
      card_size = SW'(131072);
      @(negedge clk);
   endtask

   task automatic t_other();
      cmd(6'd17, 32'(5 << GSH));
      chk("R11 no response", 64'({rsp_valid, illegal, erase_done}), 0);
      chk("R11 no state", 64'({status, wp_bits}), 64'({5'b0, 32'h20}));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_protect();
      t_write();
      t_clear_race();
      t_erase_std();
      t_hc();
      t_other();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule